// File: doc/BRIEF.md
# Soft-Start Current-Limit Setpoint Ramp

This block produces the digital current-limit setpoint for a hot-swap pass switch. The first time the supply rises above its undervoltage lockout point after reset, the block takes one snapshot of the external charge-current and rise-time settings. A setting that is absent is replaced by a built-in default. The snapshot does not change until the next reset.

When the gate is switched on, the setpoint climbs in a straight line from zero to the charge-current level. It reaches that level exactly after the programmed number of clock cycles, so the load capacitor charges without a current step on the input line. When the switch reports that it is fully enhanced, the setpoint changes to the fixed operating limit. Removing the gate or asserting abort clears the setpoint at once, and the next gate-on starts the ramp again from zero.

Setpoints are 10-bit codes in units of 1 mA. The rise time is a count of clock cycles. A one-time serial division converts the captured target and rise time into a per-cycle step and a fractional remainder.

Top module: `soft_start_ramp`

## Requirements
- R1: While rst_ni is low, setpoint_o is 0 and no configuration is held.
- R2: The configuration is captured only on the first rising edge of uvlo_ok_i after reset. Later changes of the codes, or a fall and rise of uvlo_ok_i, have no effect on later ramps.
- R3: If ext_chg_present_i is low at capture, the charge target is 100 and the rise time is 1000 cycles.
- R4: A present external charge code is clamped into 50..500. A rise code of 0 is treated as 1 cycle.
- R5: ext_rise_code_i is used only when ext_chg_present_i and ext_rise_present_i are both high at capture. Otherwise the rise time is 1000 cycles.
- R6: Let edge 0 be the clock edge at which the gate is first sampled on with the block idle and ready. At edge k, the setpoint is floor(T*k/N) for k < N. At edge N it equals T, where T is the target and N is the rise time. It then holds T.
- R7: full_enh_i sampled high while ramping or holding sets the setpoint to OP_LIM (750) at that edge. This takes priority over the final ramp step in the same cycle. full_enh_i is ignored while idle.
- R8: setpoint_o is 0 in any cycle where gate_on_i is low or abort_i is high. Abort takes priority over full enhancement. After either, the next gate-on restarts the ramp at 0.
- R9: Until the configuration is captured and its step is derived, gate_on_i has no effect and setpoint_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uvlo_ok_i | input | 1 | Supply is above the undervoltage lockout point |
| ext_chg_present_i | input | 1 | An external charge-current setting is fitted |
| ext_rise_present_i | input | 1 | An external rise-time setting is fitted |
| ext_chg_code_i | input | CODE_W | Measured external charge current, in mA |
| ext_rise_code_i | input | RISE_W | Measured external rise time, in cycles |
| gate_on_i | input | 1 | The pass switch gate is on |
| full_enh_i | input | 1 | The pass switch is fully enhanced |
| abort_i | input | 1 | Fault abort |
| setpoint_o | output | CODE_W | Current-limit setpoint code, in mA |

## Verification
Full enhancement can arrive in the same cycle as the ramp's last step. Abort can also arrive in the same cycle as full enhancement. The bench forces the first case by raising full_enh_i exactly on the edge where the count would reach the rise time, and expects the operating limit rather than the charge target. It forces the second case by holding abort_i high while full_enh_i is raised, and expects zero on the setpoint. It then expects a clean ramp from zero once abort is released.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RAMP = 2'd1,
    RS_HOLD = 2'd2,
    RS_RUN  = 2'd3
  } ramp_st_e;
endpackage

// File: rtl/ssr_cfg_latch.sv
module ssr_cfg_latch #(
  parameter int CODE_W   = 10,
  parameter int RISE_W   = 12,
  parameter int CHG_MIN  = 50,
  parameter int CHG_MAX  = 500,
  parameter int DEF_CHG  = 100,
  parameter int DEF_RISE = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uvlo_ok_i,
  input  logic              chg_present_i,
  input  logic              rise_present_i,
  input  logic [CODE_W-1:0] chg_code_i,
  input  logic [RISE_W-1:0] rise_code_i,
  output logic [CODE_W-1:0] chg_o,
  output logic [RISE_W-1:0] rise_o,
  output logic              valid_o,
  output logic              load_o
);
  localparam logic [CODE_W-1:0] MIN_C   = CODE_W'(CHG_MIN);
  localparam logic [CODE_W-1:0] MAX_C   = CODE_W'(CHG_MAX);
  localparam logic [CODE_W-1:0] DEFC_C  = CODE_W'(DEF_CHG);
  localparam logic [RISE_W-1:0] DEFR_C  = RISE_W'(DEF_RISE);
  localparam logic [RISE_W-1:0] ONE_C   = RISE_W'(1);

  logic              uvlo_q;
  logic              cap;
  logic [CODE_W-1:0] chg_sel;
  logic [RISE_W-1:0] rise_sel;

  // one-shot: only the first uvlo rise after reset
  assign cap = uvlo_ok_i & ~uvlo_q & ~valid_o;

  always_comb begin
    if (!chg_present_i)          chg_sel = DEFC_C;
    else if (chg_code_i < MIN_C) chg_sel = MIN_C;
    else if (chg_code_i > MAX_C) chg_sel = MAX_C;
    else                         chg_sel = chg_code_i;
  end

  always_comb begin
    if (chg_present_i && rise_present_i)
      rise_sel = (rise_code_i == '0) ? ONE_C : rise_code_i;
    else
      rise_sel = DEFR_C;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uvlo_q  <= 1'b0;
      load_o  <= 1'b0;
      valid_o <= 1'b0;
      chg_o   <= '0;
      rise_o  <= '0;
    end else begin
      uvlo_q <= uvlo_ok_i;
      load_o <= cap;
      if (cap) begin
        chg_o   <= chg_sel;
        rise_o  <= rise_sel;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssr_div.sv
module ssr_div #(
  parameter int NUM_W = 10,
  parameter int DEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial;
  logic             ge;

  assign trial = {rem_o, num_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
      rem_o  <= '0;
    end else if (start_i) begin
      num_q  <= num_i;
      den_q  <= den_i;
      cnt_q  <= CNT_W'(NUM_W);
      busy_q <= 1'b1;
      done_o <= 1'b0;
      quo_o  <= '0;
      rem_o  <= '0;
    end else if (busy_q) begin
      num_q <= num_q << 1;
      quo_o <= {quo_o[NUM_W-2:0], ge};
      rem_o <= DEN_W'(ge ? trial - {1'b0, den_q} : trial);
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssr_ramp.sv
module ssr_ramp
  import ssr_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int RISE_W = 12,
  parameter int OP_LIM = 750
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              go_i,
  input  logic              enh_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic [RISE_W-1:0] n_i,
  input  logic [CODE_W-1:0] q_i,
  input  logic [RISE_W-1:0] r_i,
  output logic [CODE_W-1:0] sp_o,
  output logic              active_o,
  output logic              run_o
);
  localparam logic [CODE_W-1:0] OP_C = CODE_W'(OP_LIM);

  ramp_st_e          st_q, st_d;
  logic [CODE_W-1:0] sp_d;
  logic [RISE_W-1:0] k_q, k_d, acc_q, acc_d;
  logic [RISE_W:0]   acc_sum;
  logic              carry;

  assign acc_sum  = {1'b0, acc_q} + {1'b0, r_i};
  assign carry    = acc_sum >= {1'b0, n_i};
  assign active_o = (st_q == RS_RAMP) || (st_q == RS_HOLD);
  assign run_o    = (st_q == RS_RUN);

  always_comb begin
    st_d  = st_q;
    sp_d  = sp_o;
    k_d   = k_q;
    acc_d = acc_q;
    unique case (st_q)
      RS_IDLE: begin
        sp_d  = '0;
        k_d   = '0;
        acc_d = '0;
        if (go_i && ready_i) st_d = RS_RAMP;
      end
      RS_RAMP: begin
        if (!go_i) begin
          st_d = RS_IDLE;
          sp_d = '0;
        end else if (enh_i) begin
          st_d = RS_RUN;
          sp_d = OP_C;
        end else begin
          k_d   = k_q + 1'b1;
          acc_d = RISE_W'(carry ? acc_sum - {1'b0, n_i} : acc_sum);
          if (k_d == n_i) begin
            sp_d = target_i;  // last step lands on target
            st_d = RS_HOLD;
          end else begin
            sp_d = sp_o + q_i + CODE_W'(carry);
          end
        end
      end
      RS_HOLD: begin
        if (!go_i) begin
          st_d = RS_IDLE;
          sp_d = '0;
        end else if (enh_i) begin
          st_d = RS_RUN;
          sp_d = OP_C;
        end
      end
      RS_RUN: begin
        if (!go_i) begin
          st_d = RS_IDLE;
          sp_d = '0;
        end
      end
      default: begin
        st_d = RS_IDLE;
        sp_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RS_IDLE;
      sp_o  <= '0;
      k_q   <= '0;
      acc_q <= '0;
    end else begin
      st_q  <= st_d;
      sp_o  <= sp_d;
      k_q   <= k_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/soft_start_ramp.sv
module soft_start_ramp #(
  parameter int CODE_W   = 10,
  parameter int RISE_W   = 12,
  parameter int CHG_MIN  = 50,
  parameter int CHG_MAX  = 500,
  parameter int DEF_CHG  = 100,
  parameter int DEF_RISE = 1000,
  parameter int OP_LIM   = 750
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uvlo_ok_i,
  input  logic              ext_chg_present_i,
  input  logic              ext_rise_present_i,
  input  logic [CODE_W-1:0] ext_chg_code_i,
  input  logic [RISE_W-1:0] ext_rise_code_i,
  input  logic              gate_on_i,
  input  logic              full_enh_i,
  input  logic              abort_i,
  output logic [CODE_W-1:0] setpoint_o
);
  logic [CODE_W-1:0] target;
  logic [RISE_W-1:0] rise_n;
  logic              cfg_valid;
  logic              cfg_load;
  logic [CODE_W-1:0] step_q;
  logic [RISE_W-1:0] step_r;
  logic              cfg_ready;
  logic              go;
  logic [CODE_W-1:0] sp_reg;
  logic              ramping;
  logic              running;

  assign go = gate_on_i & ~abort_i;

  ssr_cfg_latch #(
    .CODE_W(CODE_W), .RISE_W(RISE_W), .CHG_MIN(CHG_MIN), .CHG_MAX(CHG_MAX),
    .DEF_CHG(DEF_CHG), .DEF_RISE(DEF_RISE)
  ) u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .uvlo_ok_i      (uvlo_ok_i),
    .chg_present_i  (ext_chg_present_i),
    .rise_present_i (ext_rise_present_i),
    .chg_code_i     (ext_chg_code_i),
    .rise_code_i    (ext_rise_code_i),
    .chg_o          (target),
    .rise_o         (rise_n),
    .valid_o        (cfg_valid),
    .load_o         (cfg_load)
  );

  ssr_div #(.NUM_W(CODE_W), .DEN_W(RISE_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cfg_load),
    .num_i   (target),
    .den_i   (rise_n),
    .quo_o   (step_q),
    .rem_o   (step_r),
    .done_o  (cfg_ready)
  );

  ssr_ramp #(.CODE_W(CODE_W), .RISE_W(RISE_W), .OP_LIM(OP_LIM)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (cfg_ready),
    .go_i     (go),
    .enh_i    (full_enh_i),
    .target_i (target),
    .n_i      (rise_n),
    .q_i      (step_q),
    .r_i      (step_r),
    .sp_o     (sp_reg),
    .active_o (ramping),
    .run_o    (running)
  );

  // drop to zero in the same cycle as gate-off or abort
  assign setpoint_o = go ? sp_reg : '0;
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
  parameter int CODE_W  = 10,
  parameter int CHG_MIN = 50,
  parameter int CHG_MAX = 500,
  parameter int OP_LIM  = 750
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gate_on_i,
  input logic              abort_i,
  input logic              full_enh_i,
  input logic [CODE_W-1:0] setpoint_o,
  input logic [CODE_W-1:0] target,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic              ramping,
  input logic              running
);
  logic go_c;
  assign go_c = gate_on_i && !abort_i;

  a_r9_wait_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ready |-> setpoint_o == '0);

  a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid |-> (target >= CODE_W'(CHG_MIN)) && (target <= CODE_W'(CHG_MAX)));

  a_r2_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid && $past(cfg_valid) |-> $stable(target));

  a_r6_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> setpoint_o <= target);

  a_r6_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_c && $past(go_c) |-> setpoint_o >= $past(setpoint_o));

  a_r7_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_c && $past(go_c && full_enh_i && ramping) |-> setpoint_o == CODE_W'(OP_LIM));

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_on_i) |-> setpoint_o == '0);
endmodule

bind soft_start_ramp ssr_chk #(
  .CODE_W(CODE_W), .CHG_MIN(CHG_MIN), .CHG_MAX(CHG_MAX), .OP_LIM(OP_LIM)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gate_on_i  (gate_on_i),
  .abort_i    (abort_i),
  .full_enh_i (full_enh_i),
  .setpoint_o (setpoint_o),
  .target     (target),
  .cfg_valid  (cfg_valid),
  .cfg_ready  (cfg_ready),
  .ramping    (ramping),
  .running    (running)
);

// File: tb/tb_soft_start_ramp.sv
`timescale 1ns/1ps
module tb_soft_start_ramp;
  localparam int OP = 750;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        uvlo_ok_i = 1'b0;
  logic        ext_chg_present_i = 1'b0;
  logic        ext_rise_present_i = 1'b0;
  logic [9:0]  ext_chg_code_i = '0;
  logic [11:0] ext_rise_code_i = '0;
  logic        gate_on_i = 1'b0;
  logic        full_enh_i = 1'b0;
  logic        abort_i = 1'b0;
  logic [9:0]  setpoint_o;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk_i = ~clk_i;

  soft_start_ramp dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .uvlo_ok_i(uvlo_ok_i),
    .ext_chg_present_i(ext_chg_present_i), .ext_rise_present_i(ext_rise_present_i),
    .ext_chg_code_i(ext_chg_code_i), .ext_rise_code_i(ext_rise_code_i),
    .gate_on_i(gate_on_i), .full_enh_i(full_enh_i), .abort_i(abort_i),
    .setpoint_o(setpoint_o)
  );

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: setpoint got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ramp_val(int t, int n, int k);
    return (k >= n) ? t : (t * k) / n;
  endfunction

  // monitor: compares after each rising edge
  always begin
    @(posedge clk_i);
    #5;
    if (exp_q.size() > 0) chk(int'(setpoint_o), exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic tick(int exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    uvlo_ok_i = 1'b0; full_enh_i = 1'b0; abort_i = 1'b0;
    gate_on_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(int'(setpoint_o), 0, "R1");
    gate_on_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic cfg(bit pc, bit pr, int chg, int rise);
    ext_chg_present_i = pc;
    ext_rise_present_i = pr;
    ext_chg_code_i = 10'(chg);
    ext_rise_code_i = 12'(rise);
    uvlo_ok_i = 1'b1;
    repeat (20) tick(0, "R9");
  endtask

  task automatic ramp(int t, int n, int k0, int k1, string tag);
    gate_on_i = 1'b1;
    for (int k = k0; k <= k1; k++) tick(ramp_val(t, n, k), tag);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R9: gate and enhancement before capture
    gate_on_i = 1'b1; full_enh_i = 1'b1;
    repeat (4) tick(0, "R9");
    gate_on_i = 1'b0; full_enh_i = 1'b0;
    // R3: defaults, codes present but flagged absent
    cfg(1'b0, 1'b0, 300, 7);
    ramp(100, 1000, 0, 1000, "R3");
    repeat (3) tick(100, "R6");
    full_enh_i = 1'b1; tick(OP, "R7");
    full_enh_i = 1'b0; tick(OP, "R7");
    gate_on_i = 1'b0; tick(0, "R8");
    ramp(100, 1000, 0, 20, "R8");
    gate_on_i = 1'b0; tick(0, "R8");

    // external 300 mA over 7 cycles
    do_reset();
    cfg(1'b1, 1'b1, 300, 7);
    gate_on_i = 1'b1; full_enh_i = 1'b1; tick(0, "R7");  // ignored while idle
    full_enh_i = 1'b0;
    ramp(300, 7, 1, 3, "R6");
    full_enh_i = 1'b1; tick(OP, "R7");
    full_enh_i = 1'b0;
    abort_i = 1'b1; tick(0, "R8");
    full_enh_i = 1'b1; tick(0, "R8");  // abort wins
    abort_i = 1'b0; full_enh_i = 1'b0;
    ramp(300, 7, 0, 7, "R8");
    tick(300, "R6");
    // R2: no recapture
    ext_chg_code_i = 10'd45; ext_rise_code_i = 12'd3;
    uvlo_ok_i = 1'b0; tick(300, "R2");
    uvlo_ok_i = 1'b1; tick(300, "R2");
    gate_on_i = 1'b0; tick(0, "R2");
    ramp(300, 7, 0, 7, "R2");
    // enhancement on the final step
    gate_on_i = 1'b0; tick(0, "R8");
    ramp(300, 7, 0, 6, "R6");
    full_enh_i = 1'b1; tick(OP, "R7");
    full_enh_i = 1'b0; gate_on_i = 1'b0; tick(0, "R8");

    // R4: clamping
    do_reset();
    cfg(1'b1, 1'b1, 20, 5);
    ramp(50, 5, 0, 5, "R4");
    do_reset();
    cfg(1'b1, 1'b1, 900, 0);
    ramp(500, 1, 0, 1, "R4");
    tick(500, "R4");

    // R5: rise code needs a charge setting
    do_reset();
    cfg(1'b0, 1'b1, 300, 4);
    ramp(100, 1000, 0, 1000, "R5");
    do_reset();
    cfg(1'b1, 1'b0, 250, 4);
    ramp(250, 1000, 0, 1000, "R5");
    gate_on_i = 1'b0; tick(0, "R8");

    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule